// File: doc/BRIEF.md
# Sector Write-Lock Register Bank

This block keeps a small control register for every 64 KB sector of a serial flash array and uses those registers to decide whether an array-modifying request may proceed. A command front end presents one command per cycle: a lock-register read or write addressed by sector, or a program or erase request whose address must be screened. For each program or erase request the block returns a one-cycle allow/deny verdict that the execution engine uses to start or refuse the operation.

Each register holds a write-lock bit, which denies modification of its sector, and a lock-down bit. Once the lock-down bit is set, the register is frozen until the next power-up reset. Lock-register writes need the write-enable latch, which is held by a neighbouring command guard. This block tells the guard when to drop the latch. A separate veto input from the higher-level protection logic can block lock-register writes without stopping the latch from being cleared.

Top module: `sector_lock_array`

## Requirements
- R1: After reset (synchronous, active high) every write-lock and lock-down bit is 0, and `rd_valid_o`, `chk_valid_o` and `wel_clr_o` are 0.
- R2: A command with `cmd_op`=1 (lock read) returns `rd_valid_o`=1 one cycle later. `rd_data_o` then holds write lock in bit 0, lock down in bit 1 and zero in bits 7:2, for the sector given by `cmd_addr[ADDR_W-1:16]`.
- R3: A command with `cmd_op`=2 (lock write) that has `wel_i`=1 and `lock_veto_i`=0, aimed at a sector whose lock-down bit is 0, loads write lock from `cmd_wdata[0]` and lock down from `cmd_wdata[1]`.
- R4: A lock write with `wel_i`=0 changes no register and produces no `wel_clr_o` pulse.
- R5: A lock write with `lock_veto_i`=1 changes no register.
- R6: When a sector's lock-down bit is 1, lock writes to that sector change nothing, and no command can clear lock down. Only reset clears it.
- R7: `wel_clr_o` pulses for one cycle, one cycle after every lock write presented with `wel_i`=1, including writes that R5 or R6 ignore.
- R8: A page program (`cmd_op`=3), subsector erase (4) or sector erase (5) gives `chk_valid_o`=1 one cycle later, with `chk_allow_o` equal to the inverse of the addressed sector's write-lock bit.
- R9: A bulk erase (`cmd_op`=6) gives `chk_valid_o`=1 one cycle later, with `chk_allow_o`=1 only when no sector has write lock set.
- R10: With `cmd_valid`=0, or with `cmd_op`=0, no output strobe rises and no register changes. At most one of `rd_valid_o`, `chk_valid_o`, `wel_clr_o` is high in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 lock read, 2 lock write, 3 program, 4 subsector erase, 5 sector erase, 6 bulk erase) |
| cmd_addr | input | ADDR_W | Byte address; upper bits select the sector |
| cmd_wdata | input | 8 | Lock-write data byte |
| wel_i | input | 1 | Write-enable latch state from the command guard |
| lock_veto_i | input | 1 | Higher-level protection blocks lock writes |
| rd_valid_o | output | 1 | Lock read data valid |
| rd_data_o | output | 8 | Lock register contents |
| chk_valid_o | output | 1 | Program/erase verdict valid |
| chk_allow_o | output | 1 | 1 = operation allowed, 0 = protected |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |

## Verification
The bench targets the ignored-write cases: a write without the latch, a vetoed write, and writes to a locked-down sector. A design that got these wrong would let a later read show changed bits. It would also drop or invent the latch-clear pulse for writes that were ignored but still completed. Bulk erase is tested with one locked sector and with none, and with the lock at the highest sector index, where a reduction that misses one bit would wrongly allow the erase. A second reset checks that lock down is cleared only by power-up, and that the sector becomes writable again afterwards.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

    localparam int LR_WIDTH  = 8;
    localparam int LR_WL_BIT = 0;
    localparam int LR_LD_BIT = 1;

    typedef enum logic [2:0] {
        LK_NOP       = 3'd0,
        LK_RDREG     = 3'd1,
        LK_WRREG     = 3'd2,
        LK_PROG      = 3'd3,
        LK_SUBERASE  = 3'd4,
        LK_SECERASE  = 3'd5,
        LK_BULKERASE = 3'd6
    } lk_op_e;

    typedef struct packed {
        logic down;
        logic wlock;
    } lk_entry_t;

    typedef struct packed {
        logic rd;        // lock register read
        logic wr;        // lock register write, qualified
        logic wel_drop;  // lock write completed with latch set
        logic chk;       // per-sector program/erase screen
        logic bulk;      // whole-array erase screen
    } lk_req_t;

    function automatic logic [LR_WIDTH-1:0] lk_pack(lk_entry_t e);
        logic [LR_WIDTH-1:0] r;
        r            = '0;
        r[LR_WL_BIT] = e.wlock;
        r[LR_LD_BIT] = e.down;
        return r;
    endfunction

    function automatic logic lk_is_sector_check(lk_op_e op);
        return (op == LK_PROG) || (op == LK_SUBERASE) || (op == LK_SECERASE);
    endfunction

endpackage

// File: rtl/seclock_decode.sv
module seclock_decode
    import seclock_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int SECT_SHIFT = 16,
    localparam int SEC_W     = ADDR_W - SECT_SHIFT
) (
    input  logic               cmd_valid,
    input  lk_op_e             cmd_op,
    input  logic [SEC_W-1:0]   cmd_sec,
    input  logic               wel,
    input  logic               veto,
    output lk_req_t            req,
    output logic [SEC_W-1:0]   sec
);

    always_comb begin
        req          = '0;
        sec          = cmd_sec;
        if (cmd_valid) begin
            unique case (cmd_op)
                LK_RDREG: req.rd = 1'b1;
                LK_WRREG: begin
                    req.wr       = wel & ~veto;
                    req.wel_drop = wel;
                end
                LK_BULKERASE: req.bulk = 1'b1;
                default: req.chk = lk_is_sector_check(cmd_op);
            endcase
        end
    end

endmodule

// File: rtl/seclock_bank.sv
module seclock_bank
    import seclock_pkg::*;
#(
    parameter int NUM_SECT = 32,
    localparam int SEC_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEC_W-1:0]    wr_sec,
    input  logic [LR_WIDTH-1:0] wr_data,
    output logic [NUM_SECT-1:0] wl_vec,
    output logic [NUM_SECT-1:0] ld_vec
);

    lk_entry_t new_entry;
    assign new_entry.wlock = wr_data[LR_WL_BIT];
    assign new_entry.down  = wr_data[LR_LD_BIT];

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
        lk_entry_t ent;
        logic      hit;

        assign hit = wr_en && (wr_sec == SEC_W'(g)) && !ent.down;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent <= '0;
            end else if (hit) begin
                ent <= new_entry;
            end
        end

        assign wl_vec[g] = ent.wlock;
        assign ld_vec[g] = ent.down;
    end

endmodule

// File: rtl/seclock_resp.sv
module seclock_resp
    import seclock_pkg::*;
#(
    parameter int NUM_SECT = 32,
    localparam int SEC_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  lk_req_t             req,
    input  logic [SEC_W-1:0]    sec,
    input  logic [NUM_SECT-1:0] wl_vec,
    input  logic [NUM_SECT-1:0] ld_vec,
    output logic                rd_valid,
    output logic [LR_WIDTH-1:0] rd_data,
    output logic                chk_valid,
    output logic                chk_allow,
    output logic                wel_clr
);

    lk_entry_t sel;
    logic      any_locked;
    logic      allow_nxt;

    always_comb begin
        sel.wlock  = wl_vec[sec];
        sel.down   = ld_vec[sec];
        any_locked = |wl_vec;
        allow_nxt  = req.bulk ? !any_locked : !sel.wlock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            chk_valid <= 1'b0;
            chk_allow <= 1'b0;
            wel_clr   <= 1'b0;
        end else begin
            rd_valid  <= req.rd;
            rd_data   <= req.rd ? lk_pack(sel) : '0;
            chk_valid <= req.chk | req.bulk;
            chk_allow <= (req.chk | req.bulk) & allow_nxt;
            wel_clr   <= req.wel_drop;
        end
    end

endmodule

// File: rtl/sector_lock_array.sv
module sector_lock_array
    import seclock_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int SECT_SHIFT = 16,
    localparam int SEC_W     = ADDR_W - SECT_SHIFT,
    localparam int NUM_SECT  = 1 << SEC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wel_i,
    input  logic              lock_veto_i,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o,
    output logic              chk_valid_o,
    output logic              chk_allow_o,
    output logic              wel_clr_o
);

    lk_req_t             req;
    logic [SEC_W-1:0]    sec;
    logic [NUM_SECT-1:0] wl_vec;
    logic [NUM_SECT-1:0] ld_vec;
    logic                unused_addr_lo;

    assign unused_addr_lo = ^cmd_addr[SECT_SHIFT-1:0];

    seclock_decode #(
        .ADDR_W     (ADDR_W),
        .SECT_SHIFT (SECT_SHIFT)
    ) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (lk_op_e'(cmd_op)),
        .cmd_sec   (cmd_addr[ADDR_W-1:SECT_SHIFT]),
        .wel       (wel_i),
        .veto      (lock_veto_i),
        .req       (req),
        .sec       (sec)
    );

    seclock_bank #(
        .NUM_SECT (NUM_SECT)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.wr),
        .wr_sec  (sec),
        .wr_data (cmd_wdata),
        .wl_vec  (wl_vec),
        .ld_vec  (ld_vec)
    );

    seclock_resp #(
        .NUM_SECT (NUM_SECT)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sec       (sec),
        .wl_vec    (wl_vec),
        .ld_vec    (ld_vec),
        .rd_valid  (rd_valid_o),
        .rd_data   (rd_data_o),
        .chk_valid (chk_valid_o),
        .chk_allow (chk_allow_o),
        .wel_clr   (wel_clr_o)
    );

endmodule

// File: rtl/seclock_chk.sv
module seclock_chk #(
    parameter int ADDR_W     = 21,
    parameter int SECT_SHIFT = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [7:0]        cmd_wdata,
    input logic              wel_i,
    input logic              lock_veto_i,
    input logic              rd_valid_o,
    input logic [7:0]        rd_data_o,
    input logic              chk_valid_o,
    input logic              chk_allow_o,
    input logic              wel_clr_o
);

    logic unused_chk;
    assign unused_chk = ^{cmd_addr, cmd_wdata, lock_veto_i, chk_allow_o};

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid_o && !chk_valid_o && !wel_clr_o));

    // R2
    rd_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1) |=> rd_valid_o);

    // R2
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> (rd_data_o[7:2] == 6'd0));

    // R7
    welclr_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd2 && wel_i) |=> wel_clr_o);

    // R4
    welclr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wel_clr_o |-> $past(cmd_valid && cmd_op == 3'd2 && wel_i));

    // R8
    verdict_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op >= 3'd3 && cmd_op <= 3'd6) |=> chk_valid_o);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_valid_o, chk_valid_o, wel_clr_o}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_op == 3'd0) |=> (!rd_valid_o && !chk_valid_o && !wel_clr_o));

endmodule

bind sector_lock_array seclock_chk #(
    .ADDR_W     (ADDR_W),
    .SECT_SHIFT (SECT_SHIFT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .wel_i       (wel_i),
    .lock_veto_i (lock_veto_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .chk_valid_o (chk_valid_o),
    .chk_allow_o (chk_allow_o),
    .wel_clr_o   (wel_clr_o)
);

// File: tb/test_sector_lock_array.sv
`timescale 1ns/1ps
module test_sector_lock_array;
    import seclock_pkg::*;

    localparam int ADDR_W = 21;

    typedef struct packed {
        lk_op_e     op;
        logic [4:0] sec;
        logic [7:0] wd;
        logic       wel;
        logic       veto;
        logic       erv;
        logic [7:0] erd;
        logic       ecv;
        logic       eal;
        logic       ewc;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VT [NV] = '{
        '{LK_RDREG,     5'd0,  8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R2
        '{LK_PROG,      5'd3,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R8
        '{LK_BULKERASE, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R9
        '{LK_WRREG,     5'd3,  8'h01, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        '{LK_RDREG,     5'd3,  8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0}, // R3
        '{LK_PROG,      5'd3,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R8
        '{LK_SUBERASE,  5'd3,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R8
        '{LK_SECERASE,  5'd4,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R8
        '{LK_BULKERASE, 5'd9,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R9
        '{LK_WRREG,     5'd3,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
        '{LK_RDREG,     5'd3,  8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0}, // R4
        '{LK_WRREG,     5'd3,  8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R5
        '{LK_RDREG,     5'd3,  8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0}, // R5
        '{LK_WRREG,     5'd3,  8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        '{LK_RDREG,     5'd3,  8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R3
        '{LK_BULKERASE, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R9
        '{LK_WRREG,     5'd31, 8'h03, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        '{LK_RDREG,     5'd31, 8'h00, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0}, // R3
        '{LK_WRREG,     5'd31, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R6
        '{LK_RDREG,     5'd31, 8'h00, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0}, // R6
        '{LK_BULKERASE, 5'd0,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R9
        '{LK_WRREG,     5'd7,  8'hFE, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R3
        '{LK_RDREG,     5'd7,  8'h00, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0}, // R2
        '{LK_WRREG,     5'd7,  8'h01, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R6
        '{LK_RDREG,     5'd7,  8'h00, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0}, // R6
        '{LK_PROG,      5'd7,  8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R8
        '{LK_NOP,       5'd7,  8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}  // R10
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_wdata = 8'h00;
    logic              wel_i = 1'b0;
    logic              lock_veto_i = 1'b0;
    logic              rd_valid_o;
    logic [7:0]        rd_data_o;
    logic              chk_valid_o;
    logic              chk_allow_o;
    logic              wel_clr_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sector_lock_array #(.ADDR_W(ADDR_W), .SECT_SHIFT(16)) i_sector_lock_array (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wel_i(wel_i),
        .lock_veto_i(lock_veto_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .chk_valid_o(chk_valid_o), .chk_allow_o(chk_allow_o), .wel_clr_o(wel_clr_o)
    );

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(lk_op_e op);
        case (op)
            LK_RDREG:     return "R2";
            LK_WRREG:     return "R7";
            LK_BULKERASE: return "R9";
            LK_NOP:       return "R10";
            default:      return "R8";
        endcase
    endfunction

    // drive one command at a falling edge, sample the registered result at the next one
    task automatic issue(lk_op_e op, logic [4:0] sec, logic [7:0] wd, logic wel, logic veto, logic vld);
        @(negedge clk);
        cmd_valid   = vld;
        cmd_op      = op;
        cmd_addr    = {sec, 16'hA5C3};
        cmd_wdata   = wd;
        wel_i       = wel;
        lock_veto_i = veto;
        @(negedge clk);
        cmd_valid   = 1'b0;
        wel_i       = 1'b0;
        lock_veto_i = 1'b0;
    endtask

    task automatic expect_idle(string tag);
        check(tag, "rd_valid", {7'd0, rd_valid_o}, 8'h00);
        check(tag, "chk_valid", {7'd0, chk_valid_o}, 8'h00);
        check(tag, "wel_clr", {7'd0, wel_clr_o}, 8'h00);
    endtask

    task automatic expect_read(string tag, logic [7:0] exp);
        check(tag, "rd_valid", {7'd0, rd_valid_o}, 8'h01);
        check(tag, "rd_data", rd_data_o, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R1");
        issue(LK_RDREG, 5'd31, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_read("R1", 8'h00);

        for (int i = 0; i < NV; i++) begin
            issue(VT[i].op, VT[i].sec, VT[i].wd, VT[i].wel, VT[i].veto, 1'b1);
            check(op_tag(VT[i].op), $sformatf("vec%0d rd_valid", i), {7'd0, rd_valid_o}, {7'd0, VT[i].erv});
            if (VT[i].erv)
                check("R2", $sformatf("vec%0d rd_data", i), rd_data_o, VT[i].erd);
            check(op_tag(VT[i].op), $sformatf("vec%0d chk_valid", i), {7'd0, chk_valid_o}, {7'd0, VT[i].ecv});
            if (VT[i].ecv)
                check(op_tag(VT[i].op), $sformatf("vec%0d chk_allow", i), {7'd0, chk_allow_o}, {7'd0, VT[i].eal});
            check("R7", $sformatf("vec%0d wel_clr", i), {7'd0, wel_clr_o}, {7'd0, VT[i].ewc});
        end

        // R10: commands without cmd_valid do nothing
        issue(LK_WRREG, 5'd5, 8'h01, 1'b1, 1'b0, 1'b0);
        expect_idle("R10");
        issue(LK_RDREG, 5'd5, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_idle("R10");
        issue(LK_RDREG, 5'd5, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_read("R10", 8'h00);

        // R1 / R6: only reset clears lock down
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_idle("R1");
        issue(LK_RDREG, 5'd31, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_read("R1", 8'h00);
        issue(LK_RDREG, 5'd7, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_read("R6", 8'h00);
        issue(LK_WRREG, 5'd7, 8'h01, 1'b1, 1'b0, 1'b1);
        issue(LK_RDREG, 5'd7, 8'h00, 1'b0, 1'b0, 1'b1);
        expect_read("R6", 8'h01);
        issue(LK_BULKERASE, 5'd0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R9", "chk_allow", {7'd0, chk_allow_o}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule